// File: doc/BRIEF.md
# Playback Terminal-Count Interrupt

This block sits beside a playback DMA channel and counts the bytes that the DMA engine hands to the audio path. Software programs a 16-bit sample count as a high byte and a low byte, and a frame shift that turns samples into bytes. When the running byte total reaches the scaled count, the block raises the playback interrupt and starts the next period from zero.

The same block owns the DMA request. The request follows the playback enable with one register stage, and each new start clears the byte total. An optional stop-on-count mode holds the request low while an interrupt is waiting, so the channel pauses at each period boundary until software acknowledges it. Without that option, transfers run on and the interrupt only marks the boundary.

Top module: `pbtc_top`

## Requirements
- R1: After reset, `dma_req` and `irq` are 0.
- R2: `dma_req` is 1 in the cycle after a cycle with `play_en` high, unless held by R8, and 0 in the cycle after a cycle with `play_en` low.
- R3: The byte target is `{cnt_hi, cnt_lo}` shifted left by `frame_shift` bits. With `irq_en` high, `irq` becomes 1 in the cycle after the accepted byte that brings the total to the target.
- R4: Reaching the target resets the total to zero, so the next interrupt needs a further full target of accepted bytes.
- R5: While `irq_en` is low, accepted bytes are still counted but never raise `irq`.
- R6: A rising playback enable (`play_en` high while the block is not yet running) clears the byte total, and any partial count is lost.
- R7: `irq` stays 1 until a cycle with `irq_ack` high clears it for the next cycle. If a new target hit and `irq_ack` fall in the same cycle, `irq` stays 1.
- R8: With `stop_on_cnt` high, `dma_req` is 0 while `irq` is 1, and it returns in the cycle after `irq` clears. With `stop_on_cnt` low, a pending `irq` does not affect `dma_req`.
- R9: A `byte_ack` pulse in a cycle where `dma_req` is 0 is ignored and does not advance the total.
- R10: A programmed count of zero never raises `irq`, however many bytes are accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| play_en | input | 1 | Playback enable |
| irq_en | input | 1 | Enables the terminal-count interrupt |
| stop_on_cnt | input | 1 | Pause the DMA request while an interrupt is pending |
| cnt_hi | input | CNT_W/2 | Upper byte of the sample count |
| cnt_lo | input | CNT_W/2 | Lower byte of the sample count |
| frame_shift | input | SHIFT_W | Left shift from samples to bytes |
| byte_ack | input | 1 | One byte accepted by the DMA engine in this cycle |
| irq_ack | input | 1 | Software clears the pending interrupt |
| dma_req | output | 1 | DMA request to the channel |
| irq | output | 1 | Playback interrupt, level |

## Verification
On every cycle, the assertions check that the request follows the enable and respects the stop-on-count hold, that the pending interrupt holds until it is acknowledged, that a target hit always sets it, that a disabled interrupt never rises, and that the total moves only on accepted bytes or on a start. Whether the interrupt lands on exactly the right byte for a given count and shift, whether a restart discards a partial period, and whether a zero count stays silent depend on sequences of bytes, so only the bench scenarios can show them. The bench drives directed sequences for each boundary and then random strobes, acknowledgements and configuration changes against a cycle model.

// File: rtl/pbtc_pkg.sv
package pbtc_pkg;

    // Default widths of the count registers and the frame shift.
    localparam int DEF_CNT_W   = 16;
    localparam int DEF_SHIFT_W = 2;

    // Events produced per cycle by the byte path.
    typedef struct packed {
        logic accept;   // byte taken while the request was up
        logic hit;      // that byte completed the period
    } tc_evt_t;

    // Width of the byte total for a given count width and shift width.
    function automatic int xfer_width(input int cnt_w, input int shift_w);
        return cnt_w + (1 << shift_w) - 1;
    endfunction

endpackage

// File: rtl/pbtc_run_ctl.sv
module pbtc_run_ctl (
    input  logic clk,
    input  logic rst,
    input  logic play_en,
    input  logic hold,
    output logic running,
    output logic start,
    output logic dma_req
);
    logic running_q;

    always_ff @(posedge clk) begin
        if (rst) running_q <= 1'b0;
        else     running_q <= play_en;
    end

    assign running = running_q;
    assign start   = play_en & ~running_q;
    assign dma_req = running_q & ~hold;

    // R2: request follows the enable one cycle later
    assert_req_follows_en_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(play_en) && !hold) |-> dma_req);
    assert_req_drops_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(play_en)) |-> !dma_req);
endmodule

// File: rtl/pbtc_counter.sv
module pbtc_counter #(
    parameter int XFER_W = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              accept,
    input  logic              limit_on,
    input  logic [XFER_W-1:0] target,
    output logic              hit
);
    logic [XFER_W-1:0] xfer_q;
    logic [XFER_W-1:0] xfer_inc;

    assign xfer_inc = xfer_q + XFER_W'(1);
    assign hit      = accept & limit_on & (target != '0) & (xfer_inc == target);

    always_ff @(posedge clk) begin
        if (rst || clr)  xfer_q <= '0;
        else if (hit)    xfer_q <= '0;
        else if (accept) xfer_q <= xfer_inc;
    end

    // R9: total only moves on an accepted byte or a start
    assert_idle_stable_R9: assert property (@(posedge clk) disable iff (rst)
        (!accept && !clr) |=> $stable(xfer_q));
    // R4: a completed period leaves the total at zero
    assert_wrap_on_hit_R4: assert property (@(posedge clk) disable iff (rst)
        hit |=> (xfer_q == '0));
    // R6: a start discards the partial total
    assert_clear_on_start_R6: assert property (@(posedge clk) disable iff (rst)
        clr |=> (xfer_q == '0));
endmodule

// File: rtl/pbtc_irq_flag.sv
module pbtc_irq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic ack,
    output logic pend
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst)      pend_q <= 1'b0;
        else if (set) pend_q <= 1'b1;
        else if (ack) pend_q <= 1'b0;
    end

    assign pend = pend_q;

    // R7: pending level holds until acknowledged
    assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !ack) |=> pend_q);
    // R3: a completed period always leaves the interrupt pending
    assert_irq_on_hit_R3: assert property (@(posedge clk) disable iff (rst)
        set |=> pend_q);
endmodule

// File: rtl/pbtc_top.sv
module pbtc_top
    import pbtc_pkg::*;
#(
    parameter int CNT_W   = DEF_CNT_W,
    parameter int SHIFT_W = DEF_SHIFT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               play_en,
    input  logic               irq_en,
    input  logic               stop_on_cnt,
    input  logic [CNT_W/2-1:0] cnt_hi,
    input  logic [CNT_W/2-1:0] cnt_lo,
    input  logic [SHIFT_W-1:0] frame_shift,
    input  logic               byte_ack,
    input  logic               irq_ack,
    output logic               dma_req,
    output logic               irq
);
    localparam int XFER_W = xfer_width(CNT_W, SHIFT_W);

    logic              running;
    logic              start;
    logic              hold;
    logic              pend;
    logic [XFER_W-1:0] target;
    tc_evt_t           evt;

    assign target     = XFER_W'({cnt_hi, cnt_lo}) << frame_shift;
    assign hold       = stop_on_cnt & pend;
    assign evt.accept = byte_ack & dma_req;

    pbtc_run_ctl u_run (
        .clk     (clk),
        .rst     (rst),
        .play_en (play_en),
        .hold    (hold),
        .running (running),
        .start   (start),
        .dma_req (dma_req)
    );

    pbtc_counter #(.XFER_W(XFER_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clr      (start),
        .accept   (evt.accept),
        .limit_on (irq_en),
        .target   (target),
        .hit      (evt.hit)
    );

    pbtc_irq_flag u_flag (
        .clk  (clk),
        .rst  (rst),
        .set  (evt.hit),
        .ack  (irq_ack),
        .pend (pend)
    );

    assign irq = pend;

    // R8: stop-on-count pauses the request while an interrupt waits
    assert_stop_gates_req_R8: assert property (@(posedge clk) disable iff (rst)
        (stop_on_cnt && irq) |-> !dma_req);
    // R5: without the enable no interrupt can appear
    assert_no_irq_disabled_R5: assert property (@(posedge clk) disable iff (rst)
        (!irq_en && !irq) |=> !irq);
    // R1/R2: no request while playback has not been running
    assert_req_needs_run_R2: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> running);
endmodule

// File: tb/pbtc_top_bench.sv
module pbtc_top_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       play_en = 1'b0, irq_en = 1'b0, stop_on_cnt = 1'b0;
    logic [7:0] cnt_hi = 8'd0, cnt_lo = 8'd0;
    logic [1:0] frame_shift = 2'd0;
    logic       byte_ack = 1'b0, irq_ack = 1'b0;
    logic       dma_req, irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic        m_run, m_irq;
    logic [18:0] m_cnt;

    always #10 clk = ~clk;

    pbtc_top u_pbtc_top (
        .clk(clk), .rst(rst), .play_en(play_en), .irq_en(irq_en),
        .stop_on_cnt(stop_on_cnt), .cnt_hi(cnt_hi), .cnt_lo(cnt_lo),
        .frame_shift(frame_shift), .byte_ack(byte_ack), .irq_ack(irq_ack),
        .dma_req(dma_req), .irq(irq)
    );

    function automatic logic [18:0] byte_target(input logic [7:0] h,
                                                 input logic [7:0] l,
                                                 input logic [1:0] s);
        return 19'({h, l}) << s;
    endfunction

    function automatic logic exp_req();
        return m_run && !(stop_on_cnt && m_irq);
    endfunction

    task automatic check(input logic ok, input string tag, input string what,
                         input logic act, input logic exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Advance one clock: model next state from current inputs, then compare.
    task automatic step(input string tag);
        logic        acc, set;
        logic [18:0] tgt, n_cnt;
        logic        n_irq;
        acc   = byte_ack && exp_req();
        tgt   = byte_target(cnt_hi, cnt_lo, frame_shift);
        set   = 1'b0;
        n_cnt = m_cnt;
        if (play_en && !m_run) n_cnt = '0;
        else if (acc) begin
            if (irq_en && tgt != '0 && (m_cnt + 19'd1) == tgt) begin
                n_cnt = '0;
                set   = 1'b1;
            end else n_cnt = m_cnt + 19'd1;
        end
        n_irq = set ? 1'b1 : (irq_ack ? 1'b0 : m_irq);
        @(posedge clk);
        @(negedge clk);
        m_run = play_en;
        m_cnt = n_cnt;
        m_irq = n_irq;
        check(dma_req == exp_req(), tag, "dma_req", dma_req, exp_req());
        check(irq == m_irq, tag, "irq", irq, m_irq);
    endtask

    task automatic bytes(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            byte_ack = 1'b1;
            step(tag);
        end
        byte_ack = 1'b0;
    endtask

    task automatic ack_irq(input string tag);
        irq_ack = 1'b1;
        step(tag);
        irq_ack = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4231));
        m_run = 1'b0; m_irq = 1'b0; m_cnt = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check(dma_req == 1'b0, "R1", "dma_req", dma_req, 1'b0);
        check(irq == 1'b0, "R1", "irq", irq, 1'b0);

        // R9: strobes before playback are ignored
        bytes(3, "R9");

        // R2: request rises one cycle after enable
        play_en = 1'b1; irq_en = 1'b1;
        cnt_hi = 8'd0; cnt_lo = 8'd3; frame_shift = 2'd1;   // target 6
        step("R2");
        check(dma_req == 1'b1, "R2", "dma_req", dma_req, 1'b1);

        // R3: irq after exactly 6 bytes
        bytes(5, "R3");
        check(irq == 1'b0, "R3", "irq early", irq, 1'b0);
        bytes(1, "R3");
        check(irq == 1'b1, "R3", "irq at target", irq, 1'b1);
        // R8: stop off, request stays up with irq pending
        check(dma_req == 1'b1, "R8", "dma_req no stop", dma_req, 1'b1);

        // R7: holds until ack, then clears
        step("R7");
        check(irq == 1'b1, "R7", "irq held", irq, 1'b1);
        ack_irq("R7");
        check(irq == 1'b0, "R7", "irq cleared", irq, 1'b0);

        // R4: next period needs another 6
        bytes(5, "R4");
        check(irq == 1'b0, "R4", "irq early", irq, 1'b0);
        // R7: hit and ack together keep irq set
        byte_ack = 1'b1; irq_ack = 1'b1;
        step("R7");
        byte_ack = 1'b0; irq_ack = 1'b0;
        check(irq == 1'b1, "R7", "set beats ack", irq, 1'b1);
        ack_irq("R7");

        // R5: interrupt disabled, bytes counted silently
        irq_en = 1'b0;
        bytes(20, "R5");
        check(irq == 1'b0, "R5", "irq disabled", irq, 1'b0);

        // R6: restart clears partial total
        irq_en = 1'b1;
        play_en = 1'b0; step("R6");
        check(dma_req == 1'b0, "R2", "dma_req off", dma_req, 1'b0);
        play_en = 1'b1; step("R6");
        bytes(4, "R6");
        play_en = 1'b0; step("R6");
        bytes(2, "R9");
        play_en = 1'b1; step("R6");
        bytes(5, "R6");
        check(irq == 1'b0, "R6", "partial dropped", irq, 1'b0);
        bytes(1, "R6");
        check(irq == 1'b1, "R6", "fresh period", irq, 1'b1);
        ack_irq("R6");

        // R8: stop-on-count pauses the request
        stop_on_cnt = 1'b1;
        cnt_lo = 8'd2; frame_shift = 2'd0;   // target 2
        bytes(2, "R8");
        check(dma_req == 1'b0, "R8", "dma_req paused", dma_req, 1'b0);
        bytes(4, "R8");   // ignored while paused
        ack_irq("R8");
        check(dma_req == 1'b1, "R8", "dma_req resumed", dma_req, 1'b1);
        bytes(1, "R8");
        check(irq == 1'b0, "R8", "paused bytes not counted", irq, 1'b0);
        bytes(1, "R8");
        check(irq == 1'b1, "R8", "second period", irq, 1'b1);
        ack_irq("R8");
        stop_on_cnt = 1'b0;

        // R10: zero count never fires
        cnt_hi = 8'd0; cnt_lo = 8'd0; frame_shift = 2'd3;
        play_en = 1'b0; step("R10");
        play_en = 1'b1; step("R10");
        bytes(40, "R10");
        check(irq == 1'b0, "R10", "zero count", irq, 1'b0);

        // Random mix checked against the cycle model
        cnt_lo = 8'd3; frame_shift = 2'd0;
        for (int i = 0; i < 4000; i++) begin
            byte_ack = ($urandom % 10) < 6;
            irq_ack  = ($urandom % 20) == 0;
            if (($urandom % 100) == 0) play_en = ~play_en;
            if (($urandom % 50) == 0) stop_on_cnt = ~stop_on_cnt;
            if (($urandom % 40) == 0) irq_en = ($urandom % 4) != 0;
            if (($urandom % 60) == 0) begin
                cnt_hi = 8'd0;
                cnt_lo = 8'($urandom % 6);
                frame_shift = 2'($urandom % 4);
            end
            step("R3");
        end
        byte_ack = 1'b0; irq_ack = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule